// File: doc/BRIEF.md
# Two-Digit BCD Range Counter

This block is a synchronous decimal counter made of two cascaded 4-bit BCD digit stages. It steps through the values 05, 06, …, 66, 67. On the enabled edge that follows 67 it reloads 05 and starts the next lap, so one lap is 63 states. The counter does not wrap from 99 to 00. Each digit stage is a presettable synchronous counter with a parallel load, and all stages share one load strobe. That strobe fires at the terminal value, or whenever the state is not a legal member of the range.

The packed BCD value is an output, with the tens digit in the upper nibble. Each digit also feeds its own seven-segment decoder, so the count can be shown as two decimal digits on active-high segment lines. A count enable stops the counter without losing its state. A synchronous active-high reset forces the start value.

Top module: `bcd_range_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count_bcd` becomes 8'h05 after that edge, whatever the value of `cnt_en`.
- R2: With `rst` low and `cnt_en` high, each rising edge raises the decimal value by one, for every value from 05 through 66.
- R3: The ones digit goes from 9 to 0 on the same edge where the tens digit rises by one. On every other enabled edge inside the range, the tens digit keeps its value.
- R4: An enabled edge at 67 gives 05, so the output around the turn-around point reads 65, 66, 67, 05, 06.
- R5: With `rst` low and `cnt_en` low, `count_bcd` holds its value across any number of edges. This includes holding at 67, where no reload happens.
- R6: `count_bcd[7:4]` carries the tens digit and `count_bcd[3:0]` carries the ones digit, each coded as binary 0 to 9.
- R7: `seg_tens` and `seg_ones` are active-high, with bit 0 = a through bit 6 = g. The digit patterns are 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D, 7=7'h07, 8=7'h7F and 9=7'h6F. A code above 9 drives all segments off.
- R8: After reset, `count_bcd` always holds valid BCD digits within 05 to 67. Any other state, such as a digit above 9, is replaced by 05 on the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the start value |
| cnt_en | input | 1 | Count enable; low freezes both digits |
| count_bcd | output | 8 | Packed BCD count, tens in [7:4], ones in [3:0] |
| seg_tens | output | 7 | Segment pattern {g,f,e,d,c,b,a} for the tens digit |
| seg_ones | output | 7 | Segment pattern {g,f,e,d,c,b,a} for the ones digit |

## Verification
The assertions assume that reset is applied at the first clock edge, so that before any check runs the digits hold a legal value rather than the unknown power-up contents. They also assume that `cnt_en` and `rst` are stable around each rising edge. The bench holds reset high from time zero and changes inputs only at falling edges. The out-of-range recovery in R8 cannot be reached through the ports after a reset, so the bench confirms it indirectly: every sampled state must lie within 05 to 67 with valid digits.

// File: rtl/bcd_range_pkg.sv
package bcd_range_pkg;

    localparam int DIGIT_W    = 4;
    localparam int NUM_DIGITS = 2;
    localparam int COUNT_W    = DIGIT_W * NUM_DIGITS;
    localparam int SEG_W      = 7;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [SEG_W-1:0]   seg_t;

    typedef struct packed {
        digit_t tens;
        digit_t ones;
    } bcd_pair_t;

    localparam digit_t DIGIT_MAX = digit_t'(9);

    // Decimal digit at position idx (0 = ones) of a non-negative integer.
    function automatic digit_t dec_digit(input int value, input int idx);
        int v;
        v = value;
        for (int k = 0; k < idx; k++) begin
            v = v / 10;
        end
        return digit_t'(v % 10);
    endfunction

    // Active-high segments, bit 0 = a ... bit 6 = g.
    function automatic seg_t seg_pattern(input digit_t d);
        seg_t s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
    import bcd_range_pkg::*;
#(
    parameter digit_t RESET_VAL = digit_t'(0)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  digit_t load_val,
    input  logic   step,
    output digit_t q,
    output logic   carry
);

    digit_t q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= RESET_VAL;
        end else if (load) begin
            q_r <= load_val;
        end else if (step) begin
            if (q_r >= DIGIT_MAX) begin
                q_r <= '0;
            end else begin
                q_r <= q_r + digit_t'(1);
            end
        end
    end

    // Ripple-free carry into the next stage: asserted when this stage wraps.
    assign carry = step && (q_r == DIGIT_MAX);
    assign q     = q_r;

endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
    import bcd_range_pkg::*;
(
    input  digit_t digit,
    output seg_t   seg
);

    always_comb begin
        seg = seg_pattern(digit);
    end

endmodule

// File: rtl/bcd_range_counter.sv
module bcd_range_counter
    import bcd_range_pkg::*;
#(
    parameter int START_VAL = 5,
    parameter int END_VAL   = 67
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    output logic [7:0] count_bcd,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_ones
);

    localparam bcd_pair_t START_BCD = '{tens: dec_digit(START_VAL, 1),
                                        ones: dec_digit(START_VAL, 0)};
    localparam bcd_pair_t END_BCD   = '{tens: dec_digit(END_VAL, 1),
                                        ones: dec_digit(END_VAL, 0)};

    digit_t               digits    [NUM_DIGITS];
    digit_t               start_dig [NUM_DIGITS];
    seg_t                 segs      [NUM_DIGITS];
    logic [NUM_DIGITS:0]  chain;
    bcd_pair_t            cur;
    logic                 digits_ok;
    logic                 in_range;
    logic                 at_end;
    logic                 reload;

    assign start_dig[0] = START_BCD.ones;
    assign start_dig[1] = START_BCD.tens;

    assign cur.ones = digits[0];
    assign cur.tens = digits[1];

    // Legal-state and terminal detection.
    always_comb begin
        digits_ok = (cur.ones <= DIGIT_MAX) && (cur.tens <= DIGIT_MAX);
        in_range  = (cur >= START_BCD) && (cur <= END_BCD);
        at_end    = (cur == END_BCD);
        reload    = cnt_en && (at_end || !digits_ok || !in_range);
    end

    assign chain[0] = cnt_en && !reload;

    genvar i;
    generate
        for (i = 0; i < NUM_DIGITS; i++) begin : g_digit
            bcd_digit_stage #(
                .RESET_VAL (dec_digit(START_VAL, i))
            ) u_stage (
                .clk      (clk),
                .rst      (rst),
                .load     (reload),
                .load_val (start_dig[i]),
                .step     (chain[i]),
                .q        (digits[i]),
                .carry    (chain[i+1])
            );

            bcd_seg_decoder u_seg (
                .digit (digits[i]),
                .seg   (segs[i])
            );
        end
    endgenerate

    assign count_bcd = cur;
    assign seg_ones  = segs[0];
    assign seg_tens  = segs[1];

endmodule

// File: rtl/bcd_range_chk.sv
module bcd_range_chk #(
    parameter logic [7:0] START_BCD = 8'h05,
    parameter logic [7:0] END_BCD   = 8'h67
) (
    input logic       clk,
    input logic       rst,
    input logic       cnt_en,
    input logic [7:0] count_bcd,
    input logic [6:0] seg_ones,
    input logic [6:0] seg_tens
);

    logic legal;
    assign legal = (count_bcd[3:0] <= 4'd9) && (count_bcd[7:4] <= 4'd9)
                   && (count_bcd >= START_BCD) && (count_bcd <= END_BCD);

    // R1
    a_r1_reset_loads_start: assert property (@(posedge clk)
        rst |=> (count_bcd == START_BCD));

    // R2
    a_r2_ones_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && legal && count_bcd != END_BCD && count_bcd[3:0] != 4'd9)
        |=> (count_bcd[3:0] == $past(count_bcd[3:0]) + 4'd1)
            && (count_bcd[7:4] == $past(count_bcd[7:4])));

    // R3
    a_r3_tens_carry: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && legal && count_bcd[3:0] == 4'd9)
        |=> (count_bcd[3:0] == 4'd0)
            && (count_bcd[7:4] == $past(count_bcd[7:4]) + 4'd1));

    // R4
    a_r4_wrap_to_start: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count_bcd == END_BCD) |=> (count_bcd == START_BCD));

    // R5
    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count_bcd));

    // R8
    a_r8_stays_legal: assert property (@(posedge clk) disable iff (rst)
        legal);

    // R7
    a_r7_segs_nonzero: assert property (@(posedge clk) disable iff (rst)
        legal |-> (seg_ones != 7'h00) && (seg_tens != 7'h00));

endmodule

bind bcd_range_counter bcd_range_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .count_bcd (count_bcd),
    .seg_ones  (seg_ones),
    .seg_tens  (seg_tens)
);

// File: tb/bcd_range_counter_tb.sv
module bcd_range_counter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [7:0] count_bcd;
    logic [6:0] seg_tens;
    logic [6:0] seg_ones;

    int n_checks = 0;
    int n_fails  = 0;
    int ref_val  = 0;

    always #4 clk = ~clk;

    bcd_range_counter u_dut (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .count_bcd (count_bcd),
        .seg_tens  (seg_tens),
        .seg_ones  (seg_ones)
    );

    function automatic logic [6:0] exp_seg(input int d);
        logic [6:0] s;
        case (d)
            0: s = 7'h3F; 1: s = 7'h06; 2: s = 7'h5B; 3: s = 7'h4F;
            4: s = 7'h66; 5: s = 7'h6D; 6: s = 7'h7D; 7: s = 7'h07;
            8: s = 7'h7F; 9: s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    // Called at a falling edge: drive, cross one rising edge, return at the next falling edge.
    task automatic tick(input logic r, input logic e);
        rst    = r;
        cnt_en = e;
        @(posedge clk);
        if (r)      ref_val = 5;
        else if (e) ref_val = (ref_val == 67) ? 5 : ref_val + 1;
        @(negedge clk);
    endtask

    task automatic check_val(input string req, input logic [7:0] exp);
        n_checks++;
        if (count_bcd !== exp) begin
            n_fails++;
            $display("FAIL %s: count_bcd=%h expected %h", req, count_bcd, exp);
        end
    endtask

    task automatic check_full(input string req);
        logic [7:0] exp;
        exp = to_bcd(ref_val);
        check_val(req, exp);
        n_checks++;
        if (seg_ones !== exp_seg(ref_val % 10) || seg_tens !== exp_seg(ref_val / 10)) begin
            n_fails++;
            $display("FAIL R7: segs tens=%h ones=%h expected %h %h",
                     seg_tens, seg_ones, exp_seg(ref_val / 10), exp_seg(ref_val % 10));
        end
        n_checks++;
        if (count_bcd[3:0] > 4'd9 || count_bcd[7:4] > 4'd9 ||
            count_bcd < 8'h05 || count_bcd > 8'h67) begin
            n_fails++;
            $display("FAIL R8: count_bcd=%h expected within 05..67", count_bcd);
        end
    endtask

    task automatic t_reset();
        tick(1'b1, 1'b0);
        check_full("R1 reset idle");
        tick(1'b1, 1'b1);
        check_full("R1 reset enabled");
    endtask

    // Two full laps plus a few states: R2, R3, R4, R6, R7 (all ten ones digits).
    task automatic t_laps();
        for (int k = 0; k < 130; k++) begin
            tick(1'b0, 1'b1);
            check_full("R2/R3/R6 lap");
        end
    endtask

    task automatic t_wrap_window();
        logic [7:0] expect_seq [5];
        expect_seq = '{8'h65, 8'h66, 8'h67, 8'h05, 8'h06};
        while (ref_val != 65) tick(1'b0, 1'b1);
        check_val("R4 wrap 65", expect_seq[0]);
        for (int k = 1; k < 5; k++) begin
            tick(1'b0, 1'b1);
            check_val("R4 wrap window", expect_seq[k]);
        end
    endtask

    task automatic t_carry_point();
        while (ref_val != 29) tick(1'b0, 1'b1);
        check_val("R3 before carry", 8'h29);
        tick(1'b0, 1'b1);
        check_val("R3 carry 29->30", 8'h30);
        tick(1'b0, 1'b1);
        check_val("R3 tens holds", 8'h31);
    endtask

    task automatic t_hold();
        while (ref_val != 67) tick(1'b0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            tick(1'b0, 1'b0);
            check_val("R5 hold at 67", 8'h67);
        end
        tick(1'b0, 1'b1);
        check_val("R4 reload after hold", 8'h05);
        while (ref_val != 42) tick(1'b0, 1'b1);
        tick(1'b0, 1'b0);
        check_full("R5 hold at 42");
    endtask

    task automatic t_reset_midcount();
        while (ref_val != 38) tick(1'b0, 1'b1);
        tick(1'b1, 1'b1);
        check_val("R1 mid-count reset", 8'h05);
        tick(1'b0, 1'b1);
        check_val("R2 after reset", 8'h06);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_laps();
        t_wrap_window();
        t_carry_point();
        t_hold();
        t_reset_midcount();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule